// File: doc/BRIEF.md
# Ethernet Exponential Backoff Timer

This block times the retry delay after a collision on a half-duplex CSMA/CD link. Each collision of the frame in flight increments a retry count. The block then draws a pseudo-random slot count from a free-running linear-feedback shift register. Only the low K bits of the register are kept, where K grows with the retry count up to a cap of ten. The block counts that many slots of bit-time ticks and then raises a one-cycle done pulse, which tells the transmitter that it may send the frame again.

The transmit controller sends a one-cycle collision pulse when it sees a collision. It sends a one-cycle new-frame pulse before it starts on a different frame. It also supplies the bit-time tick as a single-cycle enable. The block shows busy for the length of the wait and reports the current retry count. Gap timing, jam generation and the frame data path are outside this block.

Top module: `eth_backoff_timer`

## Requirements
- R1: While reset is high and in the cycle after it is released, busy and done are 0 and the attempt count is 0.
- R2: A collision pulse without a new-frame pulse in the same cycle increments the attempt count by one in the next cycle. The count saturates at its all-ones value (31 with the default 5-bit width).
- R3: A new-frame pulse clears the attempt count to 0 and cancels any running wait without a done pulse. It wins over a collision pulse in the same cycle, and that collision pulse then has no effect.
- R4: The slot count drawn on a collision is the low K bits of the generator value in that cycle, with K = min(new attempt count, 10). After the first collision of a frame it is 0 or 1, after the second it is 0..3, and it is never more than 1023.
- R5: For a nonzero slot count r, busy is high from the cycle after the collision until the done pulse. Done is high for exactly one cycle, in the cycle after the (r × SLOT_TICKS)-th bit tick that follows the collision. SLOT_TICKS defaults to 512.
- R6: For a slot count of zero, done pulses in the cycle right after the collision and busy stays low.
- R7: The countdown advances only in cycles where the bit tick is high. Cycles without a tick leave busy unchanged.
- R8: The generator is an 11-bit maximal-length register. It shifts up by one bit on every clock. The new bit 0 is bit 10 XOR bit 8, and the register holds the value 1 after reset.
- R9: A collision pulse during a wait restarts the wait, using a fresh draw and the incremented attempt count.
- R10: Busy and done are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle enable per bit time |
| coll_start | input | 1 | One-cycle pulse when a collision is seen |
| frame_new | input | 1 | One-cycle pulse that starts a fresh frame |
| busy | output | 1 | Backoff wait in progress |
| done | output | 1 | One-cycle pulse: retransmission may start |
| attempt | output | ATTEMPT_W (5) | Collisions seen for the current frame |

## Verification
The hardest state to reach is attempt-count saturation together with the full ten-bit draw. Reaching it takes more than thirty collisions without a new frame, and a wait at the cap can run past a thousand slots. To get there, the stimulus fires collisions back to back, so that each one restarts the previous wait. It then lets a single capped wait run to completion, with a shortened slot length. A bench model of the generator, the counter and the countdown is compared against the outputs on every cycle. Random gaps in the bit tick show that only ticking cycles advance the wait.

// File: rtl/bo_pkg.sv
package bo_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } wait_state_e;

    typedef struct packed {
        logic busy;
        logic done;
    } timer_flags_t;

    // Width of the random draw for a given attempt number.
    function automatic int unsigned clamp_k(int unsigned n, int unsigned cap);
        return (n < cap) ? n : cap;
    endfunction

    // Mask with the low k bits set.
    function automatic logic [31:0] low_ones(int unsigned k);
        if (k >= 32)
            return '1;
        return (32'd1 << k) - 32'd1;
    endfunction

endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
    parameter int W     = 11,
    parameter int OUT_W = 10,
    parameter int SEED  = 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] low_bits
);
    // Tap pair per supported width; the top tap is always W-1.
    localparam int TAP_HI = W - 1;
    localparam int TAP_LO = (W == 7)  ? 5  :
                            (W == 9)  ? 4  :
                            (W == 15) ? 13 : 8;

    logic [W-1:0] q;
    logic         fb;

    generate
        if (W == 2) begin : g_tiny
            assign fb = q[1] ^ q[0];
        end else begin : g_normal
            assign fb = q[TAP_HI] ^ q[TAP_LO];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            q <= W'(SEED);
        else
            q <= {q[W-2:0], fb};
    end

    assign low_bits = q[OUT_W-1:0];

endmodule

// File: rtl/bo_attempt_ctr.sv
module bo_attempt_ctr #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          bump,
    output logic [AW-1:0] count,
    output logic [AW-1:0] count_inc
);
    assign count_inc = (count == '1) ? count : count + AW'(1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (bump)
            count <= count_inc;
    end

endmodule

// File: rtl/bo_slot_timer.sv
module bo_slot_timer
    import bo_pkg::*;
#(
    parameter int SW         = 10,
    parameter int SLOT_TICKS = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cancel,
    input  logic          load,
    input  logic [SW-1:0] load_slots,
    input  logic          tick,
    output timer_flags_t  flags
);
    localparam int TW = (SLOT_TICKS > 2) ? $clog2(SLOT_TICKS) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(SLOT_TICKS - 1);

    wait_state_e   state;
    logic [SW-1:0] slots_q;
    logic [TW-1:0] ticks_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            slots_q <= '0;
            ticks_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cancel) begin
                state   <= ST_IDLE;
                ticks_q <= '0;
            end else if (load) begin
                ticks_q <= '0;
                slots_q <= load_slots;
                if (load_slots == '0) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end else begin
                    state <= ST_WAIT;
                end
            end else if (state == ST_WAIT && tick) begin
                if (ticks_q == LAST_TICK) begin
                    ticks_q <= '0;
                    slots_q <= slots_q - SW'(1);
                    if (slots_q == SW'(1)) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end else begin
                    ticks_q <= ticks_q + TW'(1);
                end
            end
        end
    end

    assign flags.busy = (state == ST_WAIT);
    assign flags.done = done_q;

endmodule

// File: rtl/eth_backoff_timer.sv
module eth_backoff_timer
    import bo_pkg::*;
#(
    parameter int LFSR_W     = 11,
    parameter int LFSR_SEED  = 1,
    parameter int K_CAP      = 10,
    parameter int ATTEMPT_W  = 5,
    parameter int SLOT_TICKS = 512
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_tick,
    input  logic                 coll_start,
    input  logic                 frame_new,
    output logic                 busy,
    output logic                 done,
    output logic [ATTEMPT_W-1:0] attempt
);
    logic [K_CAP-1:0]     rnd_low;
    logic [ATTEMPT_W-1:0] att_inc;
    logic [K_CAP-1:0]     draw_mask;
    logic [K_CAP-1:0]     draw;
    logic                 take_coll;
    int unsigned          k_now;
    timer_flags_t         flags;

    assign take_coll = coll_start & ~frame_new;

    bo_lfsr #(
        .W     (LFSR_W),
        .OUT_W (K_CAP),
        .SEED  (LFSR_SEED)
    ) u_rng (
        .clk      (clk),
        .rst      (rst),
        .low_bits (rnd_low)
    );

    bo_attempt_ctr #(
        .AW (ATTEMPT_W)
    ) u_att (
        .clk       (clk),
        .rst       (rst),
        .clear     (frame_new),
        .bump      (take_coll),
        .count     (attempt),
        .count_inc (att_inc)
    );

    always_comb begin
        k_now     = clamp_k(32'(att_inc), K_CAP);
        draw_mask = K_CAP'(low_ones(k_now));
        draw      = rnd_low & draw_mask;
    end

    bo_slot_timer #(
        .SW         (K_CAP),
        .SLOT_TICKS (SLOT_TICKS)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .cancel     (frame_new),
        .load       (take_coll),
        .load_slots (draw),
        .tick       (bit_tick),
        .flags      (flags)
    );

    assign busy = flags.busy;
    assign done = flags.done;

endmodule

// File: rtl/bo_timer_checker.sv
module bo_timer_checker #(
    parameter int ATTEMPT_W = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bit_tick,
    input logic                 coll_start,
    input logic                 frame_new,
    input logic                 busy,
    input logic                 done,
    input logic [ATTEMPT_W-1:0] attempt
);
    p_attempt_step_r2: assert property (@(posedge clk) disable iff (rst)
        (coll_start && !frame_new && attempt != '1) |=> attempt == $past(attempt) + ATTEMPT_W'(1));

    p_attempt_sat_r2: assert property (@(posedge clk) disable iff (rst)
        (coll_start && !frame_new && attempt == '1) |=> attempt == '1);

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        frame_new |=> (attempt == '0 && !busy && !done));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !coll_start) |=> !done);

    p_tick_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_tick && !coll_start && !frame_new) |=> (busy && !done));

    p_attempt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!coll_start && !frame_new) |=> $stable(attempt));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

bind eth_backoff_timer bo_timer_checker #(.ATTEMPT_W(ATTEMPT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .coll_start (coll_start),
    .frame_new  (frame_new),
    .busy       (busy),
    .done       (done),
    .attempt    (attempt)
);

// File: tb/sim_eth_backoff_timer.sv
`timescale 1ns/1ps
module sim_eth_backoff_timer;
    localparam int ST   = 4;
    localparam int AW   = 5;
    localparam int KCAP = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b0;
    logic coll_start = 1'b0;
    logic frame_new = 1'b0;
    logic busy, done;
    logic [AW-1:0] attempt;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_mode = 1; // 1: every cycle, 0: random
    bit finished = 0;

    // reference model state
    int m_lfsr = 1, m_att = 0, m_busy = 0, m_done = 0, m_slots = 0, m_ticks = 0;

    always #5 clk = ~clk;

    eth_backoff_timer #(.SLOT_TICKS(ST)) u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .coll_start(coll_start),
        .frame_new(frame_new), .busy(busy), .done(done), .attempt(attempt)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        int k, r;
        cyc++;
        if (rst) begin
            m_lfsr = 1; m_att = 0; m_busy = 0; m_done = 0; m_slots = 0; m_ticks = 0;
        end else begin
            m_done = 0;
            if (frame_new) begin
                m_att = 0; m_busy = 0; m_ticks = 0;
            end else if (coll_start) begin
                if (m_att < 31) m_att = m_att + 1;
                k = (m_att < KCAP) ? m_att : KCAP;
                r = m_lfsr % (1 << k);
                m_ticks = 0;
                if (r == 0) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_busy = 1; m_slots = r;
                end
            end else if (m_busy == 1 && bit_tick) begin
                if (m_ticks == ST - 1) begin
                    m_ticks = 0;
                    if (m_slots == 1) begin m_busy = 0; m_done = 1; end
                    m_slots = m_slots - 1;
                end else m_ticks = m_ticks + 1;
            end
            m_lfsr = ((m_lfsr * 2) % 2048) + (((m_lfsr / 1024) ^ (m_lfsr / 256)) % 2);
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (!finished) begin
            check("R5/R6/R7 busy", int'(busy), m_busy);
            check("R5/R6 done", int'(done), m_done);
            check("R2/R3 attempt", int'(attempt), m_att);
        end
        bit_tick = tick_mode ? 1'b1 : 1'($urandom % 2);
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 190000 && !finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired: actual=%0d expected<%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse_coll();
        @(negedge clk); coll_start = 1'b1;
        @(negedge clk); coll_start = 1'b0;
    endtask

    task automatic pulse_new();
        @(negedge clk); frame_new = 1'b1;
        @(negedge clk); frame_new = 1'b0;
    endtask

    // Collide, then wait for done; returns edges from collision to done.
    task automatic collide_and_wait(output int len);
        @(negedge clk); coll_start = 1'b1;
        @(negedge clk); coll_start = 1'b0;
        len = 0;
        while (!done && len < 9000) begin
            @(negedge clk);
            len++;
        end
        #1;
    endtask

    initial begin
        int len;
        repeat (3) @(negedge clk);
        #1;
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        check("R1 attempt in reset", int'(attempt), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;
        check("R1 busy after reset", int'(busy), 0);
        check("R1 attempt after reset", int'(attempt), 0);

        // R4, R8: first collision of a frame waits 0 or 1 slot.
        collide_and_wait(len);
        check("R4 first draw in 0..1", int'(len <= 1 * ST), 1);
        check("R2 attempt after first", int'(attempt), 1);
        collide_and_wait(len);
        check("R4 second draw in 0..3", int'(len <= 3 * ST), 1);
        collide_and_wait(len);
        check("R4 third draw in 0..7", int'(len <= 7 * ST), 1);

        // R3: new frame clears count.
        pulse_new();
        #1;
        check("R3 attempt cleared", int'(attempt), 0);

        // R7: sparse ticks.
        tick_mode = 0;
        for (int i = 0; i < 5; i++) begin
            collide_and_wait(len);
            check("R7 sparse wait finished", int'(done), 1);
        end
        tick_mode = 1;

        // R9: collisions during a wait restart it.
        pulse_new();
        for (int i = 0; i < 6; i++) begin
            pulse_coll();
            repeat (2) @(negedge clk);
        end
        #1;
        check("R9 attempt after restarts", int'(attempt), 6);

        // R3: new frame cancels a running wait; wins over a same-cycle collision.
        repeat (20) begin
            if (busy) break;
            pulse_coll();
        end
        @(negedge clk); frame_new = 1'b1; coll_start = 1'b1;
        @(negedge clk); frame_new = 1'b0; coll_start = 1'b0;
        #1;
        check("R3 busy cancelled", int'(busy), 0);
        check("R3 collision ignored", int'(attempt), 0);
        repeat (10) @(negedge clk);
        check("R3 no done after cancel", int'(done), 0);

        // R2: saturation, then a full capped draw (R4).
        for (int i = 0; i < 40; i++) pulse_coll();
        #1;
        check("R2 attempt saturates", int'(attempt), 31);
        collide_and_wait(len);
        check("R4 capped draw <= 1023 slots", int'(len <= 1023 * ST), 1);
        check("R2 still saturated", int'(attempt), 31);

        // R6/R8 continued: many fresh-frame first draws.
        for (int i = 0; i < 12; i++) begin
            pulse_new();
            repeat (i) @(negedge clk);
            collide_and_wait(len);
            check("R4 fresh frame draw in 0..1", int'(len <= ST), 1);
        end

        repeat (5) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule